// File: doc/BRIEF.md
# Converter Power and Reference Enable Controller

This block decides when the converter core and the on-chip voltage reference are powered. It sits behind the serial-bus slave logic and sees only decoded events. These are a pulse for each accepted command carrying a two-bit power field, pulses for bus STOP and repeated-START conditions, and pulses marking the start and the end of each conversion. From these it drives an enable for the core, an enable for the reference, and a ready flag. The ready flag tells the sampling logic whether the reference has had time to settle.

A command can turn the reference on, but the turn-on does not happen at once. It waits for the next STOP or repeated START. A command can also turn the reference off, and that takes effect at once. Every off-to-on transition starts a fresh settling window of a programmable number of clock cycles. The core is enabled either for the span of each conversion or continuously, depending on the low bit of the last power field.

Top module: `pwrref_ctrl`

## Requirements
- R1: During and right after reset, `core_en`, `ref_en` and `ref_ready` are all low.
- R2: An accepted command whose power field has bit 1 set (reference request) while `ref_en` is low leaves `ref_en` low until a bus boundary (STOP or repeated START) is seen.
- R3: A STOP or repeated-START pulse while a reference request is pending sets `ref_en` high in the following cycle.
- R4: A command with power-field bit 1 set while `ref_en` is high keeps `ref_en` high and does not disturb `ref_ready`.
- R5: A command with power-field bit 1 clear drives `ref_en` and `ref_ready` low in the following cycle and cancels any pending request.
- R6: `ref_ready` rises exactly SETTLE_CYCLES cycles after `ref_en` rises, and is low whenever `ref_en` is low.
- R7: The settling window restarts in full on every off-to-on transition of `ref_en`.
- R8: A command with power-field bit 0 set (converter hold) makes `core_en` high from the next cycle and keeps it high while no other command arrives.
- R9: With power-field bit 0 clear, `core_en` is high from the cycle after `conv_start` up to and including the cycle of `conv_end`, and is low afterwards.
- R10: A bus boundary with no pending request does not change `ref_en` or `ref_ready`.
- R11: When a command with bit 1 clear arrives in the same cycle as a boundary that would complete a pending request, the reference stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle pulse: a command was accepted |
| cmd_pd | input | 2 | Power field; bit 1 = reference request, bit 0 = converter hold |
| bus_stop | input | 1 | One-cycle pulse on a bus STOP |
| bus_rstart | input | 1 | One-cycle pulse on a bus repeated START |
| conv_start | input | 1 | One-cycle pulse when a conversion begins |
| conv_end | input | 1 | One-cycle pulse when a conversion completes |
| core_en | output | 1 | Converter core enable |
| ref_en | output | 1 | Internal reference enable |
| ref_ready | output | 1 | Reference has settled |

## Verification
A wrongly set pending flag appears as `ref_en` rising on a boundary that should have been ignored, or not rising on one that should count. Either shows one cycle after that boundary. A settling counter that is loaded late or not reloaded moves the `ref_ready` rise away from its exact cycle offset after `ref_en`. The bench therefore checks the cycle before and the cycle of the rise, and repeats this after an off/on cycle. A stale hold or busy bit leaves `core_en` high in the cycle after a conversion ends or after a power-down command.

// File: rtl/pwrref_pkg.sv
package pwrref_pkg;

   // Decoded view of the two-bit power field.
   typedef struct packed {
      logic ref_req;    // bit 1: reference wanted
      logic conv_hold;  // bit 0: core held on
   } pwr_field_t;

   function automatic pwr_field_t unpack_pwr(input logic [1:0] raw);
      pwr_field_t f;
      f.ref_req   = raw[1];
      f.conv_hold = raw[0];
      return f;
   endfunction

endpackage

// File: rtl/pwrref_ref_ctrl.sv
module pwrref_ref_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid_i,
   input  logic ref_req_i,
   input  logic boundary_i,
   output logic ref_on_o,
   output logic turn_on_o
);

   logic pend_q;
   logic on_d, pend_d;

   // A boundary promotes a request held from earlier cycles; a command in
   // the same cycle is applied afterwards and an off request wins.
   always_comb begin
      on_d   = ref_on_o;
      pend_d = pend_q;
      if (boundary_i && pend_q) begin
         on_d   = 1'b1;
         pend_d = 1'b0;
      end
      if (cmd_valid_i) begin
         if (!ref_req_i) begin
            on_d   = 1'b0;
            pend_d = 1'b0;
         end else if (!on_d) begin
            pend_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_on_o <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         ref_on_o <= on_d;
         pend_q   <= pend_d;
      end
   end

   assign turn_on_o = on_d && !ref_on_o;

   assert_no_early_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_on_o && !boundary_i) |=> !ref_on_o);

   assert_off_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && !ref_req_i) |=> !ref_on_o);

   assert_on_cmd_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_on_o && cmd_valid_i && ref_req_i) |=> ref_on_o);

endmodule

// File: rtl/pwrref_settle.sv
module pwrref_settle #(
   parameter int SETTLE_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_on_i,
   input  logic turn_on_i,
   output logic ready_o
);

   localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);

   if (SETTLE_CYCLES < 0 || SETTLE_CYCLES > (1 << 24)) begin : g_bad_len
      $error("pwrref_settle: SETTLE_CYCLES out of range");
   end

   if (SETTLE_CYCLES == 0) begin : g_no_wait
      assign ready_o = ref_on_i && !turn_on_i;
   end else begin : g_count
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n)                cnt_q <= '0;
         else if (turn_on_i)        cnt_q <= LOAD;
         else if (!ref_on_i)        cnt_q <= '0;
         else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
      end

      assign ready_o = ref_on_i && (cnt_q == '0);

      assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
         turn_on_i |=> !ready_o);

      assert_ready_after_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ready_o) |-> $past(ref_on_i));
   end

endmodule

// File: rtl/pwrref_core_gate.sv
module pwrref_core_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid_i,
   input  logic hold_i,
   input  logic conv_start_i,
   input  logic conv_end_i,
   output logic core_en_o
);

   logic hold_q, busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         if (cmd_valid_i)       hold_q <= hold_i;
         if (conv_start_i)      busy_q <= 1'b1;
         else if (conv_end_i)   busy_q <= 1'b0;
      end
   end

   assign core_en_o = hold_q || busy_q;

   assert_hold_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && hold_i) |=> core_en_o);

   assert_start_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_i |=> core_en_o);

endmodule

// File: rtl/pwrref_ctrl.sv
module pwrref_ctrl #(
   parameter int SETTLE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_pd,
   input  logic       bus_stop,
   input  logic       bus_rstart,
   input  logic       conv_start,
   input  logic       conv_end,
   output logic       core_en,
   output logic       ref_en,
   output logic       ref_ready
);
   import pwrref_pkg::*;

   pwr_field_t fld;
   logic       boundary;
   logic       turn_on;

   assign fld      = unpack_pwr(cmd_pd);
   assign boundary = bus_stop || bus_rstart;

   pwrref_ref_ctrl u_ref (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid),
      .ref_req_i   (fld.ref_req),
      .boundary_i  (boundary),
      .ref_on_o    (ref_en),
      .turn_on_o   (turn_on)
   );

   pwrref_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_on_i  (ref_en),
      .turn_on_i (turn_on),
      .ready_o   (ref_ready)
   );

   pwrref_core_gate u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid_i  (cmd_valid),
      .hold_i       (fld.conv_hold),
      .conv_start_i (conv_start),
      .conv_end_i   (conv_end),
      .core_en_o    (core_en)
   );

   assert_ready_needs_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_en |-> !ref_ready);

endmodule

// File: tb/test_pwrref_ctrl.sv
module test_pwrref_ctrl;

   localparam int S = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_pd = 2'b00;
   logic       bus_stop = 1'b0;
   logic       bus_rstart = 1'b0;
   logic       conv_start = 1'b0;
   logic       conv_end = 1'b0;
   logic       core_en, ref_en, ref_ready;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pwrref_ctrl #(.SETTLE_CYCLES(S)) i_pwrref_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pd(cmd_pd),
      .bus_stop(bus_stop), .bus_rstart(bus_rstart),
      .conv_start(conv_start), .conv_end(conv_end),
      .core_en(core_en), .ref_en(ref_en), .ref_ready(ref_ready));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_cmd(input logic [1:0] pd);
      @(negedge clk); cmd_valid = 1'b1; cmd_pd = pd;
      @(negedge clk); cmd_valid = 1'b0;
   endtask

   task automatic bus_end(input bit use_stop);
      @(negedge clk);
      if (use_stop) bus_stop = 1'b1; else bus_rstart = 1'b1;
      @(negedge clk); bus_stop = 1'b0; bus_rstart = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "core_en", core_en, 1'b0);
      chk("R1", "ref_en", ref_en, 1'b0);
      chk("R1", "ref_ready", ref_ready, 1'b0);
   endtask

   task automatic t_defer;
      send_cmd(2'b10);
      chk("R2", "ref_en after request", ref_en, 1'b0);
      idle(3);
      chk("R2", "ref_en still waiting", ref_en, 1'b0);
      bus_end(1'b1);
      chk("R3", "ref_en after stop", ref_en, 1'b1);
      chk("R6", "ready low at turn-on", ref_ready, 1'b0);
   endtask

   task automatic t_settle;
      idle(S - 1);
      chk("R6", "ready one cycle early", ref_ready, 1'b0);
      idle(1);
      chk("R6", "ready on time", ref_ready, 1'b1);
   endtask

   task automatic t_keep;
      send_cmd(2'b11);
      chk("R4", "ref_en kept", ref_en, 1'b1);
      chk("R4", "ready kept", ref_ready, 1'b1);
      chk("R8", "core_en held", core_en, 1'b1);
      idle(5);
      chk("R8", "core_en still held", core_en, 1'b1);
      bus_end(1'b0);
      chk("R10", "ref_en after idle rstart", ref_en, 1'b1);
      chk("R10", "ready after idle rstart", ref_ready, 1'b1);
   endtask

   task automatic t_off;
      send_cmd(2'b00);
      chk("R5", "ref_en off", ref_en, 1'b0);
      chk("R5", "ready off", ref_ready, 1'b0);
      chk("R9", "core_en off with no conversion", core_en, 1'b0);
      bus_end(1'b1);
      chk("R10", "ref_en after stop with nothing pending", ref_en, 1'b0);
      send_cmd(2'b10);
      send_cmd(2'b00);
      bus_end(1'b0);
      chk("R5", "cancelled request stays off", ref_en, 1'b0);
   endtask

   task automatic t_conv_pulse;
      @(negedge clk); conv_start = 1'b1;
      @(negedge clk); conv_start = 1'b0;
      chk("R9", "core_en after start", core_en, 1'b1);
      idle(3);
      chk("R9", "core_en during conversion", core_en, 1'b1);
      @(negedge clk); conv_end = 1'b1;
      chk("R9", "core_en in end cycle", core_en, 1'b1);
      @(negedge clk); conv_end = 1'b0;
      chk("R9", "core_en after end", core_en, 1'b0);
   endtask

   task automatic t_restart;
      send_cmd(2'b10);
      bus_end(1'b0);
      chk("R3", "ref_en after rstart", ref_en, 1'b1);
      idle(4);
      send_cmd(2'b00);
      send_cmd(2'b10);
      bus_end(1'b1);
      chk("R7", "ref_en back on", ref_en, 1'b1);
      idle(S - 1);
      chk("R7", "ready not early after restart", ref_ready, 1'b0);
      idle(1);
      chk("R7", "ready after full window", ref_ready, 1'b1);
   endtask

   task automatic t_same_cycle;
      send_cmd(2'b00);
      send_cmd(2'b10);
      @(negedge clk); cmd_valid = 1'b1; cmd_pd = 2'b00; bus_stop = 1'b1;
      @(negedge clk); cmd_valid = 1'b0; bus_stop = 1'b0;
      chk("R11", "ref_en stays off", ref_en, 1'b0);
      bus_end(1'b1);
      chk("R11", "no leftover request", ref_en, 1'b0);
   endtask

   initial begin
      idle(3);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_defer();
      t_settle();
      t_keep();
      t_off();
      t_conv_pulse();
      t_restart();
      t_same_cycle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule